// File: doc/BRIEF.md
# Single-Cycle RISC Subset Core

This block is a 32-bit processor that completes one instruction per clock. It supports eight instructions in three fixed 32-bit formats: register add, register subtract, signed set-on-less-than, word load, word store, branch on equal, branch on not-equal and an absolute jump. It contains a 32 x 32-bit register file, a program counter, an instruction word array and a data word array. To branch on less-than, software runs set-on-less-than and then branches on its result against register zero.

While reset is held, the surrounding logic fills both word arrays through a load port. After reset is released, the core fetches from byte address 0. A small control machine has two states. In `ST_RUN`, one instruction retires on each clock edge. The transition `ST_RUN -> ST_HALT` is taken when the fetched word is not in the supported set. `ST_HALT` only exits through reset (`ST_HALT -> ST_RUN`). A debug read port shows any register, and the program counter and halt flag are also outputs.

Top module: `rsc_core`

## Requirements
- R1: While reset is asserted and right after it, `pc` is 0, `halted` is 0 and every register reads 0 through the debug port.
- R2: An R-format word (op=bits 31:26 = 0, rs=25:21, rt=20:16, rd=15:11, funct=5:0) with funct 32 writes rs+rt into rd, and with funct 34 writes rs-rt into rd. Both wrap modulo 2^32, and the PC then advances by 4.
- R3: funct 42 writes 1 into rd when rs < rt as two's-complement signed values, and writes 0 otherwise.
- R4: Register 0 always reads 0, and writes that target it are dropped.
- R5: op 35 loads the data word at byte address rs + sign-extended offset[15:0] into rt. op 43 stores rt to that word. Word index = address bits above bit 1.
- R6: op 4 (equal) and op 5 (not-equal) compare rs with rt. When the branch is taken, PC = PC+4 + (sign-extended offset << 2). Otherwise PC = PC+4. The PC stays word aligned.
- R7: op 2 always jumps to {PC+4[31:28], bits 25:0, 2'b00}.
- R8: An opcode outside {0,2,4,5,35,43}, or an op-0 funct outside {32,34,42}, sets `halted` on the next edge. From then on the PC is frozen and no register or memory write occurs. The offending word's own write is also suppressed.
- R9: Set-on-less-than followed by a branch against register 0 gives a correct less-than decision in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; load port active only while low |
| ld_we | input | 1 | Load-port write strobe |
| ld_dmem | input | 1 | 1 selects data array, 0 selects instruction array |
| ld_addr | input | 32 | Word index for the load port |
| ld_data | input | 32 | Word written through the load port |
| dbg_raddr | input | 5 | Register number for the debug read |
| dbg_rdata | output | 32 | Value of register `dbg_raddr` |
| pc | output | 32 | Program counter (byte address) |
| halted | output | 1 | High in `ST_HALT` |

## Verification
Several properties are checked on every cycle by the assertions. Register 0 never holds a non-zero value. The PC stays word aligned. A step that neither branches nor jumps adds exactly 4. Once halted, the core stays halted with a frozen PC and no write strobe. The signed compare agrees with a subtraction-based derivation. Other behaviour can only be shown by the bench's programs: the arithmetic results, load and store addressing with negative offsets, taken and untaken branches in both directions (including a backward loop), jump targets, and the less-than idiom.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JMP   = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT
    } alu_op_e;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } core_state_e;

    typedef struct packed {
        logic    reg_we;
        logic    dst_rd;
        logic    mem_rd;
        logic    mem_we;
        logic    branch;
        logic    br_ne;
        logic    jump;
        logic    illegal;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
    import rsc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                unique case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: begin
                        ctrl.reg_we  = 1'b0;
                        ctrl.illegal = 1'b1;
                    end
                endcase
            end
            OPC_LW: begin
                ctrl.reg_we = 1'b1;
                ctrl.mem_rd = 1'b1;
            end
            OPC_SW:  ctrl.mem_we = 1'b1;
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_BNE: begin
                ctrl.branch = 1'b1;
                ctrl.br_ne  = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OPC_JMP: ctrl.jump = 1'b1;
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
    import rsc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         eq
);

    logic [W-1:0] diff;
    logic         lt_by_diff;

    assign diff = a - b;
    assign eq   = (a == b);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    // signs differ: a is less when negative; same sign: the difference's sign
    assign lt_by_diff = (a[W-1] != b[W-1]) ? a[W-1] : diff[W-1];

    always_comb begin
        if (op == ALU_SLT) begin
            AST_SLT_SIGNED: assert (y == {{(W-1){1'b0}}, lt_by_diff}); // R3
        end
    end

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
    assign rd3 = regs[ra3];

    AST_R0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        regs[0] == '0); // R4

endmodule

// File: rtl/rsc_core.sv
module rsc_core
    import rsc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int NREG       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ld_we,
    input  logic                     ld_dmem,
    input  logic [31:0]              ld_addr,
    input  logic [XLEN-1:0]          ld_data,
    input  logic [$clog2(NREG)-1:0]  dbg_raddr,
    output logic [XLEN-1:0]          dbg_rdata,
    output logic [XLEN-1:0]          pc,
    output logic                     halted
);

    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);
    localparam int RAW = $clog2(NREG);

    core_state_e     state_q, state_d;
    logic [XLEN-1:0] pc_q, pc_d;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] instr;
    logic [RAW-1:0]  f_rs, f_rt, f_rd;
    logic [XLEN-1:0] sext_off;
    ctrl_t           ctrl;

    logic [XLEN-1:0] rs_val, rt_val, alu_b, alu_y, wdata, dm_rdata;
    logic            alu_eq, take, run, rf_we_eff, dm_we_eff;
    logic [RAW-1:0]  waddr;
    logic [XLEN-1:0] pc_plus4, br_target, jmp_target;

    // fetch and field split
    assign instr    = imem[pc_q[IAW+1:2]];
    assign f_rs     = instr[21 +: RAW];
    assign f_rt     = instr[16 +: RAW];
    assign f_rd     = instr[11 +: RAW];
    assign sext_off = {{(XLEN-16){instr[15]}}, instr[15:0]};

    rsc_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    rsc_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (f_rs),
        .ra2   (f_rt),
        .ra3   (dbg_raddr),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_rdata),
        .we    (rf_we_eff),
        .wa    (waddr),
        .wd    (wdata)
    );

    assign alu_b = (ctrl.mem_rd || ctrl.mem_we) ? sext_off : rt_val;

    rsc_alu #(.W(XLEN)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y),
        .eq (alu_eq)
    );

    assign dm_rdata  = dmem[alu_y[DAW+1:2]];
    assign wdata     = ctrl.mem_rd ? dm_rdata : alu_y;
    assign waddr     = ctrl.dst_rd ? f_rd : f_rt;
    assign run       = (state_q == ST_RUN);
    assign rf_we_eff = run && ctrl.reg_we;
    assign dm_we_eff = rst_n && run && ctrl.mem_we;

    // next-PC candidates
    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {sext_off[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[XLEN-1:28], instr[25:0], 2'b00};
    assign take       = ctrl.branch && (alu_eq ^ ctrl.br_ne);

    // next-state and next-PC process
    always_comb begin
        state_d = state_q;
        pc_d    = pc_q;
        unique case (state_q)
            ST_RUN: begin
                if (ctrl.illegal)   state_d = ST_HALT;
                else if (ctrl.jump) pc_d    = jmp_target;
                else if (take)      pc_d    = br_target;
                else                pc_d    = pc_plus4;
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: state_d = ST_HALT;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // word arrays: load port during reset, core stores afterwards
    always_ff @(posedge clk) begin
        if (!rst_n && ld_we) begin
            if (ld_dmem) dmem[ld_addr[DAW-1:0]] <= ld_data;
            else         imem[ld_addr[IAW-1:0]] <= ld_data;
        end else if (dm_we_eff) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end
    end

    // output process
    always_comb begin
        pc     = pc_q;
        halted = (state_q == ST_HALT);
    end

    logic unused_bits;
    assign unused_bits = ^{ld_addr, instr, alu_y, pc_q};

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc))); // R8
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rf_we_eff && !dm_we_eff)); // R8
    AST_PC_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00); // R6
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl.illegal && !ctrl.jump && !take) |=> (pc == $past(pc) + XLEN'(4))); // R2

endmodule

// File: tb/tb_rsc_core.sv
`timescale 1ns/1ps
module tb_rsc_core;

    localparam logic [31:0] HALT_W = 32'hFC00_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_we = 1'b0;
    logic        ld_dmem = 1'b0;
    logic [31:0] ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] pc;
    logic        halted;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [31:0] prog [64];
    logic [31:0] dat  [64];

    always #4 clk = ~clk;

    rsc_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_we     (ld_we),
        .ld_dmem   (ld_dmem),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .dbg_raddr (dbg_raddr),
        .dbg_rdata (dbg_rdata),
        .pc        (pc),
        .halted    (halted)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int off);
        return {op, 5'(rs), 5'(rt), 16'(off)};
    endfunction
    function automatic logic [31:0] enc_j(int tgt);
        return {6'd2, 26'(tgt)};
    endfunction
    function automatic logic [31:0] ref_slt(logic [31:0] a, logic [31:0] b);
        return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd_reg(int idx, output logic [31:0] v);
        dbg_raddr = 5'(idx);
        #1;
        v = dbg_rdata;
    endtask

    task automatic clear_images();
        for (int i = 0; i < 64; i++) begin
            prog[i] = HALT_W;
            dat[i]  = '0;
        end
    endtask

    task automatic load_and_start();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            ld_we   = 1'b1;
            ld_dmem = (i >= 64);
            ld_addr = 32'(i % 64);
            ld_data = (i >= 64) ? dat[i-64] : prog[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic wait_halt(string req);
        int n = 0;
        while (!halted && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, halted}, 32'd1);
    endtask

    task automatic run_arith(logic [31:0] a, logic [31:0] b, logic [31:0] c);
        logic [31:0] v;
        clear_images();
        dat[0] = a; dat[1] = b; dat[4] = 32'd40; dat[9] = c;
        prog[0]  = enc_i(6'd35, 0, 1, 0);
        prog[1]  = enc_i(6'd35, 0, 2, 4);
        prog[2]  = enc_r(1, 2, 3, 6'd32);
        prog[3]  = enc_r(1, 2, 4, 6'd34);
        prog[4]  = enc_r(1, 2, 5, 6'd42);
        prog[5]  = enc_r(2, 1, 6, 6'd42);
        prog[6]  = enc_r(1, 2, 0, 6'd32);
        prog[7]  = enc_i(6'd43, 0, 3, 8);
        prog[8]  = enc_i(6'd35, 0, 7, 8);
        prog[9]  = enc_i(6'd35, 0, 8, 16);
        prog[10] = enc_i(6'd35, 8, 9, -4);
        prog[11] = enc_i(6'd43, 8, 4, 4);
        prog[12] = enc_i(6'd35, 0, 10, 44);
        load_and_start();
        wait_halt("R8 halt reached");
        rd_reg(3, v);  chk("R2 add", v, a + b);
        rd_reg(4, v);  chk("R2 sub", v, a - b);
        rd_reg(5, v);  chk("R3 slt a<b", v, ref_slt(a, b));
        rd_reg(6, v);  chk("R3 slt b<a", v, ref_slt(b, a));
        rd_reg(0, v);  chk("R4 r0 write dropped", v, 32'd0);
        rd_reg(7, v);  chk("R5 sw/lw positive offset", v, a + b);
        rd_reg(9, v);  chk("R5 lw negative offset", v, c);
        rd_reg(10, v); chk("R5 sw via base register", v, a - b);
        chk("R2 pc advance to halt", pc, 32'd52);
    endtask

    task automatic run_branch(logic [31:0] a, logic [31:0] b);
        logic [31:0] v;
        logic [31:0] ka = 32'h1111_1111;
        logic [31:0] kb = 32'h2222_2222;
        logic eq = (a == b);
        logic lt = ($signed(a) < $signed(b));
        clear_images();
        dat[0] = a; dat[1] = b; dat[2] = ka; dat[3] = kb;
        prog[0]  = enc_i(6'd35, 0, 1, 0);
        prog[1]  = enc_i(6'd35, 0, 2, 4);
        prog[2]  = enc_i(6'd4, 1, 2, 2);
        prog[3]  = enc_i(6'd35, 0, 10, 8);
        prog[4]  = enc_j(6);
        prog[5]  = enc_i(6'd35, 0, 11, 12);
        prog[6]  = enc_i(6'd5, 1, 2, 1);
        prog[7]  = enc_i(6'd35, 0, 12, 8);
        prog[8]  = enc_r(1, 2, 3, 6'd42);
        prog[9]  = enc_i(6'd4, 3, 0, 1);
        prog[10] = enc_i(6'd35, 0, 13, 12);
        load_and_start();
        wait_halt("R8 halt reached");
        rd_reg(10, v); chk("R6 beq fall-through path", v, eq ? 32'd0 : ka);
        rd_reg(11, v); chk("R6 beq taken path", v, eq ? kb : 32'd0);
        rd_reg(12, v); chk("R6 bne", v, eq ? ka : 32'd0);
        rd_reg(13, v); chk("R9 less-than idiom", v, lt ? kb : 32'd0);
        chk("R6 final pc", pc, 32'd44);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] a, b;
        void'($urandom(32'd2718));

        // R1: reset state
        clear_images();
        load_and_start();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 pc in reset", pc, 32'd0);
        chk("R1 halted in reset", {31'd0, halted}, 32'd0);

        // directed arithmetic corners, then random
        run_arith(32'h7FFF_FFFF, 32'h0000_0001, 32'hCAFE_0001);
        run_arith(32'h8000_0000, 32'h0000_0001, 32'h0000_0002);
        run_arith(32'h1234_5678, 32'h1234_5678, 32'hFFFF_FFFF);
        run_arith(32'h0000_0000, 32'hFFFF_FFFF, 32'h0BAD_F00D);
        for (int k = 0; k < 6; k++) run_arith($urandom, $urandom, $urandom);

        // R1: registers cleared by reset after a program wrote them
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd_reg(3, v);
        chk("R1 register cleared by reset", v, 32'd0);
        chk("R1 halted cleared by reset", {31'd0, halted}, 32'd0);

        // branches and the less-than idiom
        run_branch(32'd5, 32'd5);
        run_branch(32'hFFFF_FFF0, 32'd3);
        run_branch(32'd9, 32'h8000_0000);
        run_branch(32'd3, 32'd100);
        for (int k = 0; k < 4; k++) begin
            a = $urandom;
            b = ($urandom % 2 == 0) ? a : $urandom;
            run_branch(a, b);
        end

        // backward branch loop (R6)
        for (int k = 0; k < 3; k++) begin
            int n = 1 + int'($urandom % 20);
            clear_images();
            dat[0] = 32'(n); dat[1] = 32'd1;
            prog[0] = enc_i(6'd35, 0, 1, 0);
            prog[1] = enc_i(6'd35, 0, 2, 4);
            prog[2] = enc_r(3, 2, 3, 6'd32);
            prog[3] = enc_i(6'd5, 3, 1, -2);
            load_and_start();
            wait_halt("R8 halt reached");
            rd_reg(3, v);
            chk("R6 backward loop count", v, 32'(n));
            chk("R6 loop exit pc", pc, 32'd16);
        end

        // jump (R7)
        clear_images();
        dat[0] = 32'h5A5A_A5A5;
        prog[0]  = enc_j(20);
        prog[20] = enc_i(6'd35, 0, 1, 0);
        load_and_start();
        wait_halt("R8 halt reached");
        rd_reg(1, v);
        chk("R7 jump target executed", v, 32'h5A5A_A5A5);
        chk("R7 pc after jump", pc, 32'd84);

        // illegal funct (R8)
        clear_images();
        dat[0] = 32'd77;
        prog[0] = enc_i(6'd35, 0, 1, 0);
        prog[1] = enc_r(1, 1, 15, 6'd1);
        prog[2] = enc_r(1, 1, 16, 6'd32);
        load_and_start();
        wait_halt("R8 halt on bad funct");
        chk("R8 pc frozen at bad word", pc, 32'd4);
        repeat (5) @(negedge clk);
        chk("R8 pc stays frozen", pc, 32'd4);
        chk("R8 stays halted", {31'd0, halted}, 32'd1);
        rd_reg(15, v); chk("R8 bad word writes nothing", v, 32'd0);
        rd_reg(16, v); chk("R8 no execution after halt", v, 32'd0);

        // illegal opcode (R8)
        clear_images();
        dat[0] = 32'd3;
        prog[0] = enc_i(6'd35, 0, 1, 0);
        prog[1] = enc_i(6'd8, 1, 2, 1);
        load_and_start();
        wait_halt("R8 halt on bad opcode");
        chk("R8 pc at bad opcode", pc, 32'd4);
        rd_reg(2, v); chk("R8 bad opcode writes nothing", v, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule